// File: doc/BRIEF.md
# Interrupt Enable, Delegation and Pending Register Bank

This block holds the machine-level interrupt enable, interrupt delegation, exception delegation and pending registers, and the machine and supervisor trap-vector base registers. It gives supervisor code restricted views of enable and pending, and each view is filtered through the interrupt delegation mask. A trap unit reads the register values from dedicated outputs. Trap entry, priority selection and cause encoding are handled outside this block.

Software reaches the bank through a single read-modify-write port. Each access has a register selector, a data word and a bit mask. The read data is combinational and always shows the selected register's value before the access. When the access is valid, the bits covered by the mask take the new data, the other bits keep their old value, and only the writable bits of the target register are then stored on the next clock edge. Three hardware lines drive the machine software, timer and external pending bits. Software cannot write these bits.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every stored register is zero. With the hardware lines held low, every output reads zero.
- R2: The interrupt delegation register stores only bits 1, 5 and 9. All other bits stay zero.
- R3: The interrupt enable register stores only bits 1, 3, 5, 7, 9 and 11.
- R4: The exception delegation register stores only bits 0 to 9, 11, 12, 13 and 15.
- R5: The supervisor enable view reads as enable AND interrupt delegation. A write through this view changes only enable bits whose delegation bit is set.
- R6: Software writes to the machine pending register change only bits 1, 5 and 9. The read data during the write is the pending value before the write.
- R7: Pending bits 3, 7 and 11 show the software, timer and external hardware lines as sampled at the previous clock edge. Software writes never change them.
- R8: The supervisor pending view reads as pending AND interrupt delegation. A write through it can change only bit 1, and only while bit 1 is delegated.
- R9: A write to either trap-vector register whose merged low two bits are 2 or 3 is dropped, and the old value stays. Merged low bits of 0 or 1 are stored.
- R10: Every write merges as (old AND NOT mask) OR (data AND mask). An access with the valid input low changes nothing.
- R11: Selector codes: 0 enable, 1 interrupt delegation, 2 exception delegation, 3 machine pending, 4 supervisor enable view, 5 supervisor pending view, 6 machine vector, 7 supervisor vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrValid | input | 1 | Access is a write in this cycle |
| csrSel | input | 3 | Register selector |
| csrWdata | input | XLEN | New data |
| csrWmask | input | XLEN | Bits to replace |
| csrRdata | output | XLEN | Selected register value before the access |
| hwSoftPend | input | 1 | Machine software interrupt line |
| hwTimerPend | input | 1 | Machine timer interrupt line |
| hwExtPend | input | 1 | Machine external interrupt line |
| mieOut | output | XLEN | Interrupt enable register |
| midelegOut | output | XLEN | Interrupt delegation register |
| medelegOut | output | XLEN | Exception delegation register |
| mipOut | output | XLEN | Pending register |
| mtvecOut | output | XLEN | Machine trap vector |
| stvecOut | output | XLEN | Supervisor trap vector |

## Verification
The assertions check the following on every cycle:
- The writable-bit masks of the three enable and delegation registers.
- The one-cycle path from the hardware lines to pending bits 3, 7 and 11.
- That a write through the supervisor enable view leaves non-delegated bits alone.
- That the supervisor pending view reads back masked.
- That a reserved-mode write leaves the vectors unchanged.

The bench scenarios show the rest:
- The exact merged values stored after partial masks.
- That a supervisor pending write lands only on delegated bit 1.
- That the read data equals the value before the write.
- The interplay of these rules over long random access sequences.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  typedef enum logic [2:0] {
    SEL_ENABLE  = 3'd0,
    SEL_IDELEG  = 3'd1,
    SEL_EDELEG  = 3'd2,
    SEL_PEND    = 3'd3,
    SEL_SENABLE = 3'd4,
    SEL_SPEND   = 3'd5,
    SEL_MVEC    = 3'd6,
    SEL_SVEC    = 3'd7
  } csrSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrIdeleg;
    logic wrEdeleg;
    logic wrPend;
    logic wrMvec;
    logic wrSvec;
    logic supView;
  } wrStrobe_t;

  localparam logic [15:0] ENABLE_BITS  = 16'h0AAA;
  localparam logic [15:0] IDELEG_BITS  = 16'h0222;
  localparam logic [15:0] EDELEG_BITS  = 16'hBBFF;
  localparam logic [15:0] SPEND_BITS   = 16'h0103;
  localparam int          HW_LINES     = 3;
  localparam int          HW_FIRST_BIT = 3;
  localparam int          HW_STRIDE    = 4;

endpackage

// File: rtl/irq_regs_ctrl.sv
module irq_regs_ctrl
  import irq_regs_pkg::*;
(
  input  logic       csrValid,
  input  logic [2:0] csrSel,
  output wrStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    if (csrValid) begin
      unique case (csrSel_e'(csrSel))
        SEL_ENABLE:  strobe.wrEnable = 1'b1;
        SEL_IDELEG:  strobe.wrIdeleg = 1'b1;
        SEL_EDELEG:  strobe.wrEdeleg = 1'b1;
        SEL_PEND:    strobe.wrPend   = 1'b1;
        SEL_SENABLE: begin
          strobe.wrEnable = 1'b1;
          strobe.supView  = 1'b1;
        end
        SEL_SPEND: begin
          strobe.wrPend  = 1'b1;
          strobe.supView = 1'b1;
        end
        SEL_MVEC:    strobe.wrMvec = 1'b1;
        SEL_SVEC:    strobe.wrSvec = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_regs_dp.sv
module irq_regs_dp
  import irq_regs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobe,
  input  logic [2:0]          csrSel,
  input  logic [XLEN-1:0]     csrWdata,
  input  logic [XLEN-1:0]     csrWmask,
  input  logic [HW_LINES-1:0] hwLines,
  output logic [XLEN-1:0]     csrRdata,
  output logic [XLEN-1:0]     enableQ,
  output logic [XLEN-1:0]     idelegQ,
  output logic [XLEN-1:0]     edelegQ,
  output logic [XLEN-1:0]     pendView,
  output logic [XLEN-1:0]     mvecQ,
  output logic [XLEN-1:0]     svecQ
);

  localparam logic [XLEN-1:0] ENABLE_MASK = XLEN'(ENABLE_BITS);
  localparam logic [XLEN-1:0] IDELEG_MASK = XLEN'(IDELEG_BITS);
  localparam logic [XLEN-1:0] EDELEG_MASK = XLEN'(EDELEG_BITS);
  localparam logic [XLEN-1:0] SPEND_MASK  = XLEN'(SPEND_BITS);

  logic [XLEN-1:0]     swPendQ;
  logic [HW_LINES-1:0] hwPendQ;
  logic [XLEN-1:0]     hwPendWord;
  logic [XLEN-1:0]     merged;
  logic [XLEN-1:0]     enableNext;
  logic [XLEN-1:0]     swPendMask;
  logic                vecModeOk;

  // Place the sampled hardware lines on pending bits 3, 7 and 11.
  always_comb begin
    hwPendWord = '0;
    for (int i = 0; i < HW_LINES; i++) begin
      hwPendWord[HW_FIRST_BIT + HW_STRIDE * i] = hwPendQ[i];
    end
  end

  assign pendView = swPendQ | hwPendWord;

  always_comb begin
    unique case (csrSel_e'(csrSel))
      SEL_ENABLE:  csrRdata = enableQ;
      SEL_IDELEG:  csrRdata = idelegQ;
      SEL_EDELEG:  csrRdata = edelegQ;
      SEL_PEND:    csrRdata = pendView;
      SEL_SENABLE: csrRdata = enableQ & idelegQ;
      SEL_SPEND:   csrRdata = pendView & idelegQ;
      SEL_MVEC:    csrRdata = mvecQ;
      SEL_SVEC:    csrRdata = svecQ;
      default:     csrRdata = '0;
    endcase
  end

  assign merged     = (csrRdata & ~csrWmask) | (csrWdata & csrWmask);
  assign enableNext = strobe.supView ? ((enableQ & ~idelegQ) | (merged & idelegQ))
                                     : merged;
  assign swPendMask = strobe.supView ? (csrWmask & idelegQ & SPEND_MASK & IDELEG_MASK)
                                     : (csrWmask & IDELEG_MASK);
  assign vecModeOk  = ~merged[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      idelegQ <= '0;
      edelegQ <= '0;
      swPendQ <= '0;
      hwPendQ <= '0;
      mvecQ   <= '0;
      svecQ   <= '0;
    end else begin
      hwPendQ <= hwLines;
      if (strobe.wrEnable)            enableQ <= enableNext & ENABLE_MASK;
      if (strobe.wrIdeleg)            idelegQ <= merged & IDELEG_MASK;
      if (strobe.wrEdeleg)            edelegQ <= merged & EDELEG_MASK;
      if (strobe.wrPend)              swPendQ <= (swPendQ & ~swPendMask) | (csrWdata & swPendMask);
      if (strobe.wrMvec && vecModeOk) mvecQ   <= merged;
      if (strobe.wrSvec && vecModeOk) svecQ   <= merged;
    end
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_regs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrValid,
  input  logic [2:0]      csrSel,
  input  logic [XLEN-1:0] csrWdata,
  input  logic [XLEN-1:0] csrWmask,
  output logic [XLEN-1:0] csrRdata,
  input  logic            hwSoftPend,
  input  logic            hwTimerPend,
  input  logic            hwExtPend,
  output logic [XLEN-1:0] mieOut,
  output logic [XLEN-1:0] midelegOut,
  output logic [XLEN-1:0] medelegOut,
  output logic [XLEN-1:0] mipOut,
  output logic [XLEN-1:0] mtvecOut,
  output logic [XLEN-1:0] stvecOut
);

  wrStrobe_t strobe;

  irq_regs_ctrl u_ctrl (
    .csrValid (csrValid),
    .csrSel   (csrSel),
    .strobe   (strobe)
  );

  irq_regs_dp #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .csrSel   (csrSel),
    .csrWdata (csrWdata),
    .csrWmask (csrWmask),
    .hwLines  ({hwExtPend, hwTimerPend, hwSoftPend}),
    .csrRdata (csrRdata),
    .enableQ  (mieOut),
    .idelegQ  (midelegOut),
    .edelegQ  (medelegOut),
    .pendView (mipOut),
    .mvecQ    (mtvecOut),
    .svecQ    (stvecOut)
  );

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrValid,
  input logic [2:0]      csrSel,
  input logic [XLEN-1:0] csrWdata,
  input logic [XLEN-1:0] csrWmask,
  input logic [XLEN-1:0] csrRdata,
  input logic            hwSoftPend,
  input logic            hwTimerPend,
  input logic            hwExtPend,
  input logic [XLEN-1:0] mieOut,
  input logic [XLEN-1:0] midelegOut,
  input logic [XLEN-1:0] medelegOut,
  input logic [XLEN-1:0] mipOut,
  input logic [XLEN-1:0] mtvecOut,
  input logic [XLEN-1:0] stvecOut
);

  logic mergedBit1;
  assign mergedBit1 = (csrRdata[1] & ~csrWmask[1]) | (csrWdata[1] & csrWmask[1]);

  assert_ideleg_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (midelegOut & ~XLEN'(16'h0222)) == '0);

  assert_enable_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mieOut & ~XLEN'(16'h0AAA)) == '0);

  assert_edeleg_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (medelegOut & ~XLEN'(16'hBBFF)) == '0);

  assert_senable_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrSel == 3'd4) |=> ((mieOut & ~midelegOut) == $past(mieOut & ~midelegOut)));

  assert_pend_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mipOut & ~XLEN'(16'h0AAA)) == '0);

  assert_hw_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (mipOut[3] == $past(hwSoftPend) && mipOut[7] == $past(hwTimerPend)
              && mipOut[11] == $past(hwExtPend)));

  assert_spend_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == 3'd5) |-> (csrRdata == (mipOut & midelegOut)));

  assert_mvec_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrSel == 3'd6 && mergedBit1) |=> $stable(mtvecOut));

  assert_svec_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrSel == 3'd7 && mergedBit1) |=> $stable(stvecOut));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csrValid |=> ($stable(mieOut) && $stable(midelegOut) && $stable(medelegOut)
                   && $stable(mtvecOut) && $stable(stvecOut)));

endmodule

bind irq_route_regs irq_route_regs_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrValid    (csrValid),
  .csrSel      (csrSel),
  .csrWdata    (csrWdata),
  .csrWmask    (csrWmask),
  .csrRdata    (csrRdata),
  .hwSoftPend  (hwSoftPend),
  .hwTimerPend (hwTimerPend),
  .hwExtPend   (hwExtPend),
  .mieOut      (mieOut),
  .midelegOut  (midelegOut),
  .medelegOut  (medelegOut),
  .mipOut      (mipOut),
  .mtvecOut    (mtvecOut),
  .stvecOut    (stvecOut)
);

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;

  localparam int XLEN      = 32;
  localparam int CLK_HALF  = 5;
  localparam int RAND_OPS  = 600;
  localparam int WATCHDOG  = 100000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            csrValid = 1'b0;
  logic [2:0]      csrSel = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrWmask = '0;
  logic [XLEN-1:0] csrRdata;
  logic            hwSoftPend = 1'b0, hwTimerPend = 1'b0, hwExtPend = 1'b0;
  logic [XLEN-1:0] mieOut, midelegOut, medelegOut, mipOut, mtvecOut, stvecOut;

  int checkCount = 0;
  int failCount  = 0;
  bit testDone   = 1'b0;

  // Bench-side expected state
  logic [XLEN-1:0] eEn, eId, eEd, eSw, eMv, eSv;
  logic [2:0]      eHw;

  always #(CLK_HALF) clk = ~clk;

  irq_route_regs #(.XLEN(XLEN)) u0 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrSel(csrSel),
    .csrWdata(csrWdata), .csrWmask(csrWmask), .csrRdata(csrRdata),
    .hwSoftPend(hwSoftPend), .hwTimerPend(hwTimerPend), .hwExtPend(hwExtPend),
    .mieOut(mieOut), .midelegOut(midelegOut), .medelegOut(medelegOut),
    .mipOut(mipOut), .mtvecOut(mtvecOut), .stvecOut(stvecOut)
  );

  function automatic logic [XLEN-1:0] expPend();
    logic [XLEN-1:0] p;
    p = eSw;
    p[3]  = eHw[0];
    p[7]  = eHw[1];
    p[11] = eHw[2];
    return p;
  endfunction

  function automatic logic [XLEN-1:0] expRead(input logic [2:0] sel);
    case (sel)
      3'd0: return eEn;
      3'd1: return eId;
      3'd2: return eEd;
      3'd3: return expPend();
      3'd4: return eEn & eId;
      3'd5: return expPend() & eId;
      3'd6: return eMv;
      default: return eSv;
    endcase
  endfunction

  task automatic expApply(input logic [2:0] sel, input logic [XLEN-1:0] wd,
                          input logic [XLEN-1:0] wm);
    logic [XLEN-1:0] m, k;
    m = (expRead(sel) & ~wm) | (wd & wm);
    case (sel)
      3'd0: eEn = m & 32'h0AAA;
      3'd1: eId = m & 32'h0222;
      3'd2: eEd = m & 32'hBBFF;
      3'd3: begin k = wm & 32'h0222; eSw = (eSw & ~k) | (wd & k); end
      3'd4: eEn = ((eEn & ~eId) | (m & eId)) & 32'h0AAA;
      3'd5: begin k = wm & eId & 32'h0002; eSw = (eSw & ~k) | (wd & k); end
      3'd6: if (m[1:0] < 2) eMv = m;
      default: if (m[1:0] < 2) eSv = m;
    endcase
  endtask

  task automatic check(input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    check(tag, "enable",  mieOut,     eEn);
    check(tag, "ideleg",  midelegOut, eId);
    check(tag, "edeleg",  medelegOut, eEd);
    check(tag, "pend",    mipOut,     expPend());
    check(tag, "mvec",    mtvecOut,   eMv);
    check(tag, "svec",    stvecOut,   eSv);
  endtask

  // One access: drive at negedge, check read data, then outputs after the edge.
  task automatic doOp(input string tag, input logic v, input logic [2:0] sel,
                      input logic [XLEN-1:0] wd, input logic [XLEN-1:0] wm,
                      input logic [2:0] hw);
    @(negedge clk);
    csrValid = v; csrSel = sel; csrWdata = wd; csrWmask = wm;
    {hwExtPend, hwTimerPend, hwSoftPend} = hw;
    #1;
    check(tag, "rdata", csrRdata, expRead(sel));
    @(posedge clk);
    if (v) expApply(sel, wd, wm);
    eHw = hw;
    #1;
    checkOutputs(tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!testDone) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    eEn = '0; eId = '0; eEd = '0; eSw = '0; eMv = '0; eSv = '0; eHw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkOutputs("R1");
    check("R1", "rdata", csrRdata, '0);

    // Writable-bit masks
    doOp("R2", 1, 3'd1, '1, '1, 3'b000);
    doOp("R3", 1, 3'd0, '1, '1, 3'b000);
    doOp("R4", 1, 3'd2, '1, '1, 3'b000);
    // Valid low: nothing changes
    doOp("R10", 0, 3'd0, '0, '1, 3'b000);
    // Partial mask merge on the exception delegation register
    doOp("R10", 1, 3'd2, 32'h0000_0000, 32'h0000_00F0, 3'b000);
    // Supervisor enable view: drop delegation of bit 5, then clear via view
    doOp("R5", 1, 3'd1, 32'h0000_0202, '1, 3'b000);
    doOp("R5", 1, 3'd4, '0, '1, 3'b000);
    doOp("R5", 1, 3'd4, '1, '1, 3'b000);
    // Machine pending software write; read shows old value
    doOp("R6", 1, 3'd3, '1, '1, 3'b000);
    doOp("R6", 1, 3'd3, '0, 32'h0000_0020, 3'b000);
    // Hardware lines follow, software cannot clear them
    doOp("R7", 1, 3'd3, '0, '1, 3'b101);
    doOp("R7", 1, 3'd3, '1, '1, 3'b010);
    doOp("R7", 0, 3'd3, '0, '0, 3'b000);
    // Supervisor pending view: delegated bit 1 only
    doOp("R8", 1, 3'd5, '1, '1, 3'b000);
    doOp("R8", 1, 3'd1, '0, '1, 3'b000);
    doOp("R8", 1, 3'd5, '0, '1, 3'b111);
    doOp("R8", 1, 3'd3, '0, '1, 3'b111);
    doOp("R8", 1, 3'd5, '1, '1, 3'b000);
    // Trap vectors: accepted and reserved modes
    doOp("R9", 1, 3'd6, 32'h8000_1001, '1, 3'b000);
    doOp("R9", 1, 3'd6, 32'h4444_4442, '1, 3'b000);
    doOp("R9", 1, 3'd7, 32'h2000_0100, '1, 3'b000);
    doOp("R9", 1, 3'd7, 32'h3000_0003, '1, 3'b000);
    doOp("R9", 1, 3'd7, 32'h0000_0002, 32'h0000_0002, 3'b000);
    // R11 selector codes are exercised across all eight values below.
    for (int i = 0; i < RAND_OPS; i++) begin
      logic [XLEN-1:0] wm;
      int unsigned pick;
      pick = $urandom_range(0, 3);
      wm = (pick == 0) ? '1 : (pick == 1) ? '0 : $urandom();
      doOp("R11", ($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
           $urandom(), wm, 3'($urandom_range(0, 7)));
    end
    testDone = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule